// File: doc/BRIEF.md
# Strobed Byte Capture Ring Buffer

This block takes one byte from a set of parallel input lanes every time an external ready strobe makes its active transition, and places the byte at the tail of a circular store. After every byte it stores, it answers on an acknowledge line with a single-clock pulse. The strobe pin is brought into the clock domain through a two-flop synchronizer before its edge is detected. The active transition can be chosen, and so can the true level of both the strobe and the acknowledge.

A host pulls bytes from the head of the store with a read enable, in arrival order. It may do so in the same clock in which a new byte is strobed in. The occupancy count is always visible. When the store is full, one configuration bit picks what happens next. In stop mode, further strobes are refused and no acknowledge is given. In overwrite mode, the oldest byte is thrown away to make room for the new one. A maskable interrupt line reports a full store.

Top module: `strobe_capture_buf`

## Requirements
- R1: Capacity is the parameter DEPTH (default 2048, legal up to 6000). After reset, `level` is 0, `empty` is 1, `full` is 0 and `rd_valid` is 0. `level` never exceeds DEPTH.
- R2: A capture happens at the clock edge where the synchronized strobe shows the selected transition. That is the third rising clock edge after the pin changes (two synchronizer flops, then the edge stage). The byte on `lane_data` at that edge is stored. With `cfg_edge_fall`=0 the capture is on the change to the asserted level. With `cfg_edge_fall`=1 it is on the change to the deasserted level. The other transition captures nothing.
- R3: The strobe is asserted when `rdy_in` XOR `cfg_rdy_low` is 1. `ack_out` equals the internal acknowledge pulse XOR `cfg_ack_low`, so `ack_out` idles at `cfg_ack_low`.
- R4: Every accepted capture produces an acknowledge pulse lasting exactly one clock. It is visible from the capture edge until the next edge, and `level` updates at the same edge.
- R5: With `cfg_overwrite`=0 and the store full, a capture with no read in the same clock is refused. There is no acknowledge, and `level` and the stored bytes are unchanged.
- R6: With `cfg_overwrite`=1 and the store full, a capture discards the oldest byte and stores the new one. `level` stays at DEPTH and the acknowledge is given.
- R7: `rd_en` while `empty`=0 removes the oldest byte. The byte appears on `rd_data` with `rd_valid`=1 for one clock after that edge. `rd_en` while empty is ignored and `rd_valid` stays 0.
- R8: A read and an accepted capture in the same clock both take effect and leave `level` unchanged. In stop mode a full store accepts the capture when a read happens in the same clock.
- R9: `irq_full` is 1 exactly when `cfg_irq_en`=1 and the store holds DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_overwrite | input | 1 | 1: overwrite oldest when full; 0: refuse when full |
| cfg_edge_fall | input | 1 | 1: capture on strobe deassertion; 0: on assertion |
| cfg_rdy_low | input | 1 | 1: strobe pin is low-true |
| cfg_ack_low | input | 1 | 1: acknowledge pin is low-true |
| cfg_irq_en | input | 1 | Enables the full interrupt |
| lane_data | input | DATA_W | Input lanes sampled on capture |
| rdy_in | input | 1 | External ready strobe pin (asynchronous) |
| ack_out | output | 1 | Acknowledge pin |
| rd_en | input | 1 | Host read request |
| rd_data | output | DATA_W | Oldest byte, valid with rd_valid |
| rd_valid | output | 1 | rd_data holds a byte read in the previous clock |
| level | output | $clog2(DEPTH+1) | Occupancy count |
| empty | output | 1 | Store holds no byte |
| full | output | 1 | Store holds DEPTH bytes |
| irq_full | output | 1 | Full interrupt |

## Verification
The hardest case to reach is a read that lands in the same clock as a capture on a full store. The read must hit the third clock edge after the strobe pin moves. The bench drives the pin on a falling clock edge, counts two further falling edges, and raises the read enable for exactly the clock in which the edge stage fires. This happens after the store has been filled to DEPTH in stop mode. The overwrite path is reached by setting the depth to 8 and strobing ten bytes. This is done after a reset into the inverted polarities and falling-edge capture, so the bench confirms that only the last eight bytes come back, in order.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

  // Pointer step around a ring of 'depth' slots.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one clock with optional push and pop.
  function automatic int unsigned level_next(input int unsigned lvl, input logic push,
                                             input logic pop);
    int unsigned n;
    n = lvl;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/capbuf_strobe_sync.sv
module capbuf_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic low_true,
  input  logic edge_fall,
  output logic strobe_hit
);
  logic [SYNC_STAGES-1:0] shreg;
  logic lvl_now, lvl_prev;

  // Reset to the idle pin level so no false edge appears after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= {SYNC_STAGES{low_true}};
    else        shreg <= {shreg[SYNC_STAGES-2:0], pin};
  end

  assign lvl_now = shreg[SYNC_STAGES-1] ^ low_true;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl_now;
  end

  assign strobe_hit = edge_fall ? (~lvl_now & lvl_prev) : (lvl_now & ~lvl_prev);
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_hit,
  input  logic          overwrite,
  input  logic          rd_en,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          drop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign rd_fire = rd_en & ~empty;
  assign wr_fire = strobe_hit & (~full | rd_fire | overwrite);
  assign drop    = wr_fire & full & ~rd_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_fire)          wr_ptr <= PW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (rd_fire || drop)  rd_ptr <= PW'(wrap_inc(int'(rd_ptr), DEPTH));
      level <= LW'(level_next(int'(level), wr_fire, rd_fire | drop));
    end
  end
endmodule

// File: rtl/capbuf_store.sv
module capbuf_store #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Read returns the old content when both ports hit one slot.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/strobe_capture_buf.sv
module strobe_capture_buf #(
  parameter int DEPTH       = 2048,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_overwrite,
  input  logic              cfg_edge_fall,
  input  logic              cfg_rdy_low,
  input  logic              cfg_ack_low,
  input  logic              cfg_irq_en,
  input  logic [DATA_W-1:0] lane_data,
  input  logic              rdy_in,
  output logic              ack_out,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full,
  output logic              irq_full
);
  logic          strobe_hit, wr_fire, rd_fire, drop, ack_pulse;
  logic [PW-1:0] wr_ptr, rd_ptr;

  capbuf_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(rdy_in), .low_true(cfg_rdy_low),
    .edge_fall(cfg_edge_fall), .strobe_hit(strobe_hit)
  );

  capbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe_hit(strobe_hit), .overwrite(cfg_overwrite),
    .rd_en(rd_en), .wr_fire(wr_fire), .rd_fire(rd_fire), .drop(drop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level), .full(full), .empty(empty)
  );

  capbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(lane_data),
    .re(rd_fire), .raddr(rd_ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_pulse <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      ack_pulse <= wr_fire;
      rd_valid  <= rd_fire;
    end
  end

  assign ack_out  = ack_pulse ^ cfg_ack_low;
  assign irq_full = cfg_irq_en & full;
endmodule

// File: rtl/capbuf_checker.sv
module capbuf_checker #(
  parameter int DEPTH = 2048,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_overwrite,
  input logic          strobe_hit,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          ack_pulse,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !rd_fire && !full) |=> (level == $past(level) + LW'(1)));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |=> !ack_pulse);

  p_ack_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> $past(wr_fire));

  p_stop_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_overwrite && full && strobe_hit && !rd_fire) |=> ($stable(level) && !ack_pulse));

  p_overwrite_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_overwrite && full && strobe_hit) |=> (full && ack_pulse));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> !rd_valid);

  p_rw_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(level));
endmodule

bind strobe_capture_buf capbuf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_overwrite(cfg_overwrite), .strobe_hit(strobe_hit),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .ack_pulse(ack_pulse), .rd_en(rd_en),
  .rd_valid(rd_valid), .level(level), .full(full), .empty(empty)
);

// File: tb/strobe_capture_buf_tb.sv
`timescale 1ns/1ps
module strobe_capture_buf_tb;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_overwrite = 1'b0, cfg_edge_fall = 1'b0, cfg_rdy_low = 1'b0;
  logic cfg_ack_low = 1'b0, cfg_irq_en = 1'b1;
  logic [7:0] lane_data = 8'h00;
  logic rdy_in = 1'b0, rd_en = 1'b0;
  logic ack_out, rd_valid, empty, full, irq_full;
  logic [7:0] rd_data;
  logic [LW-1:0] level;

  always #2.5 clk = ~clk;

  strobe_capture_buf #(.DEPTH(DEPTH), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_overwrite(cfg_overwrite), .cfg_edge_fall(cfg_edge_fall),
    .cfg_rdy_low(cfg_rdy_low), .cfg_ack_low(cfg_ack_low), .cfg_irq_en(cfg_irq_en),
    .lane_data(lane_data), .rdy_in(rdy_in), .ack_out(ack_out), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .level(level), .empty(empty), .full(full),
    .irq_full(irq_full)
  );

  int checks = 0, errors = 0, exp_level = 0, exp_reads = 0, seen_reads = 0;
  logic [7:0] sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every returned byte (R7).
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      seen_reads++;
      if (sb.size() == 0) check(1'b0, "R7", "read with empty scoreboard", int'(rd_data), 0);
      else begin
        logic [7:0] e;
        e = sb.pop_front();
        check(rd_data == e, "R7", "read data order", int'(rd_data), int'(e));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; rd_en = 1'b0; rdy_in = cfg_rdy_low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_level = 0;
    sb.delete();
  endtask

  // Pin has just moved at a falling edge; wait to the capture edge.
  task automatic phase(input bit is_cap, input logic [7:0] d, input bit with_read);
    bit rd, acc;
    rd = with_read && is_cap && (exp_level > 0);
    @(negedge clk);
    @(negedge clk);
    if (rd) rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (is_cap) begin
      acc = (exp_level < DEPTH) || rd || cfg_overwrite;
      if (rd) exp_reads++;
      if (acc && !rd && exp_level == DEPTH) void'(sb.pop_front());
      if (acc) sb.push_back(d);
      exp_level = exp_level + int'(acc && !(exp_level == DEPTH && !rd)) - int'(rd);
      check(ack_out == (acc ^ cfg_ack_low), acc ? "R4" : "R5", "ack on capture edge",
            int'(ack_out), int'(acc ^ cfg_ack_low));
      check(int'(level) == exp_level, "R2", "level after capture", int'(level), exp_level);
    end else begin
      check(ack_out == cfg_ack_low, "R2", "no ack on other edge", int'(ack_out),
            int'(cfg_ack_low));
    end
    check(irq_full == (cfg_irq_en && exp_level == DEPTH), "R9", "irq_full", int'(irq_full),
          int'(cfg_irq_en && exp_level == DEPTH));
    @(negedge clk);
    check(ack_out == cfg_ack_low, "R4", "ack lasts one clock", int'(ack_out), int'(cfg_ack_low));
  endtask

  task automatic strobe(input logic [7:0] d, input bit with_read);
    lane_data = d;
    rdy_in = ~cfg_rdy_low;
    phase(!cfg_edge_fall, d, with_read);
    rdy_in = cfg_rdy_low;
    phase(cfg_edge_fall, d, with_read);
  endtask

  task automatic read_one();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    exp_level--;
    exp_reads++;
    check(int'(level) == exp_level, "R7", "level after read", int'(level), exp_level);
  endtask

  task automatic read_empty();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid == 1'b0, "R7", "read of empty ignored", int'(rd_valid), 0);
    check(int'(level) == 0, "R7", "level stays 0", int'(level), 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Stop mode, high-true lines, rising capture, interrupt enabled.
    do_reset();
    check(int'(level) == 0, "R1", "reset level", int'(level), 0);
    check(empty == 1'b1, "R1", "reset empty", int'(empty), 1);
    check(full == 1'b0, "R1", "reset full", int'(full), 0);
    check(rd_valid == 1'b0, "R1", "reset rd_valid", int'(rd_valid), 0);
    check(ack_out == 1'b0, "R3", "idle ack high-true", int'(ack_out), 0);
    check(irq_full == 1'b0, "R9", "reset irq", int'(irq_full), 0);

    strobe(8'hA5, 1'b0);
    strobe(8'h3C, 1'b0);
    strobe(8'hF0, 1'b0);
    repeat (3) read_one();
    @(negedge clk);
    read_empty();

    for (int i = 0; i < DEPTH; i++) strobe(8'h10 + 8'(i), 1'b0);
    check(full == 1'b1, "R1", "full at DEPTH", int'(full), 1);
    strobe(8'hEE, 1'b0);                       // refused (R5)
    strobe(8'h77, 1'b1);                       // read + capture when full (R8)
    check(int'(level) == DEPTH, "R8", "level held on read+capture", int'(level), DEPTH);
    for (int i = 0; i < DEPTH; i++) read_one();
    @(negedge clk);

    // Overwrite mode, low-true lines, falling capture, interrupt masked.
    cfg_overwrite = 1'b1; cfg_rdy_low = 1'b1; cfg_ack_low = 1'b1;
    cfg_edge_fall = 1'b1; cfg_irq_en = 1'b0;
    do_reset();
    check(ack_out == 1'b1, "R3", "idle ack low-true", int'(ack_out), 1);
    for (int i = 0; i < DEPTH + 2; i++) strobe(8'h20 + 8'(i), 1'b0);
    check(int'(level) == DEPTH, "R6", "level stays DEPTH on overwrite", int'(level), DEPTH);
    check(irq_full == 1'b0, "R9", "irq masked", int'(irq_full), 0);
    strobe(8'h5A, 1'b1);                       // read + capture in overwrite mode (R8)
    for (int i = 0; i < DEPTH; i++) read_one();
    @(negedge clk);
    @(negedge clk);
    check(seen_reads == exp_reads, "R7", "number of bytes returned", seen_reads, exp_reads);
    check(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule